// File: doc/BRIEF.md
# Shader program upload controller

This block sits on a register-write command stream and fills the instruction memories and swizzle-pattern memories of two shader units: a primary unit and a secondary unit that can either share the primary's program or run its own. Each unit has two upload ports, one for program words and one for pattern words. Each port keeps its own write pointer, and that pointer advances by one after every word it accepts. Software first places a pointer through the port's pointer register and then streams words into the port's data window. The window spans eight consecutive addresses, and every one of them performs the same data write.

A one-bit sharing control decides whether the secondary unit follows the primary. While the secondary is not exclusive, each word accepted by a primary port is also stored at the same index in the secondary memory of the same kind. A data write whose pointer is at or past the end of its memory stores nothing and leaves the pointer as it is. It produces a one-cycle error pulse on the bit of the port that overflowed. A small read port lets a testbench look into all four memories.

Top module: `shader_upload_ctrl`

## Requirements
- R1: After reset all four pointers are 0, the sharing control is 0 (shared), `err_o` is 0 and `wr_ready` is 1.
- R2: A port's data window is `base+8` to `base+15`. A write to any of those eight addresses performs the same data write. The port bases are 0x300 (primary program), 0x310 (primary pattern), 0x200 (secondary program) and 0x210 (secondary pattern).
- R3: A data write whose pointer is below the memory depth stores `wr_data` at the pointer index. The pointer then increments by one.
- R4: A data write whose pointer is at or beyond the memory depth stores nothing and leaves the pointer unchanged. In the cycle after the write, `err_o` shows a single-cycle pulse on the overflowing port's bit: [0] primary program, [1] primary pattern, [2] secondary program, [3] secondary pattern.
- R5: Every port has its own pointer, so writes through one port do not move another port's pointer.
- R6: The sharing control is bit 0 of address 0x100. While it is 0, each word accepted by a primary port is also stored at the same index in the secondary memory of the same kind.
- R7: While the sharing control is 1, primary writes reach only the primary memories.
- R8: Writes through a secondary port never change a primary memory.
- R9: A write to a port's base address loads that port's pointer with `wr_data[15:0]`.
- R10: A write to an address outside the map changes no memory, no pointer and no control, and raises no error.
- R11: The depths are 512 words for the primary program memory, 4096 words for the secondary program memory and 128 words for each pattern memory. `rd_sel` picks a memory in the same order as the `err_o` bits. `rd_data` returns that word one cycle after `rd_sel` and `rd_addr` are applied, and returns 0 when `rd_addr` is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Command write valid |
| wr_ready | output | 1 | Always 1: every command is taken in the cycle it is offered |
| wr_addr | input | 10 | Register address of the command |
| wr_data | input | 32 | Write data of the command |
| rd_sel | input | 2 | Memory chosen for the inspection read |
| rd_addr | input | 16 | Word index for the inspection read |
| rd_data | output | 32 | Inspection read data, one cycle of latency |
| err_o | output | 4 | One-cycle overflow pulse, one bit per port |

## Verification
The assertions assume that the command stream offers at most one write per cycle and that this write holds a single address. This means that no pointer load and data write for the same port can arrive together, and that a secondary write and a mirrored primary write cannot target the same memory in the same cycle. The bench meets this by sending commands through one task that drives one address per clock. The `wr_ready` handshake never pushes back, so there is no back-pressure to model, and every command is considered taken on the edge where `wr_valid` is high. The bench preloads each memory word it later proves to be untouched, so the read port never returns undefined contents.

// File: rtl/shader_upload_pkg.sv
package shader_upload_pkg;
  localparam int unsigned ADDR_W   = 10;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned OFS_W    = 16;
  localparam int unsigned NUM_PORT = 4;

  localparam logic [ADDR_W-1:0] CFG_ADDR = 10'h100;

  // port index order: primary program, primary pattern, secondary program, secondary pattern
  typedef enum logic [1:0] {
    PORT_PRI_PROG = 2'd0,
    PORT_PRI_SWZ  = 2'd1,
    PORT_SEC_PROG = 2'd2,
    PORT_SEC_SWZ  = 2'd3
  } port_id_e;

  function automatic logic [5:0] port_region(input int idx);
    case (idx)
      0:       return 6'h30;
      1:       return 6'h31;
      2:       return 6'h20;
      default: return 6'h21;
    endcase
  endfunction
endpackage

// File: rtl/upload_port.sv
module upload_port #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [OFS_W-1:0] set_val,
  input  logic             data_en,
  output logic             wr_en,
  output logic [OFS_W-1:0] wr_idx,
  output logic             err
);
  localparam logic [OFS_W-1:0] LIMIT = OFS_W'(DEPTH);

  logic [OFS_W-1:0] ofs_q;
  logic             err_q;
  logic             in_range;

  assign in_range = ofs_q < LIMIT;
  assign wr_en    = data_en && in_range;
  assign wr_idx   = ofs_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= data_en && !in_range;
      if (set_en)     ofs_q <= set_val;
      else if (wr_en) ofs_q <= ofs_q + 1'b1;
    end
  end

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && !set_en && ofs_q < LIMIT) |=> ofs_q == $past(ofs_q) + 1'b1);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && !set_en && ofs_q >= LIMIT) |=> $stable(ofs_q));

  assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(data_en) && $past(ofs_q) >= LIMIT);

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ofs_q == $past(set_val));
endmodule

// File: rtl/shader_mem.sv
module shader_mem #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/shader_upload_ctrl.sv
module shader_upload_ctrl
  import shader_upload_pkg::*;
#(
  parameter int unsigned PRI_PROG_DEPTH = 512,
  parameter int unsigned SEC_PROG_DEPTH = 4096,
  parameter int unsigned SWZ_DEPTH      = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  input  logic [OFS_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        err_o
);
  function automatic int unsigned depth_of(input int idx);
    case (idx)
      0:       return PRI_PROG_DEPTH;
      2:       return SEC_PROG_DEPTH;
      default: return SWZ_DEPTH;
    endcase
  endfunction

  logic                wr_fire;
  logic                excl_q;
  logic [NUM_PORT-1:0] set_hit;
  logic [NUM_PORT-1:0] data_hit;
  logic [NUM_PORT-1:0] port_we;
  logic [OFS_W-1:0]    port_idx [NUM_PORT];
  logic [DATA_W-1:0]   mem_rd   [NUM_PORT];

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) excl_q <= 1'b0;
    else if (wr_fire && wr_addr == CFG_ADDR) excl_q <= wr_data[0];
  end

  for (genvar gi = 0; gi < NUM_PORT; gi++) begin : g_port
    logic region_hit;
    assign region_hit   = wr_fire && (wr_addr[9:4] == port_region(gi));
    assign set_hit[gi]  = region_hit && (wr_addr[3:0] == 4'h0);
    assign data_hit[gi] = region_hit && wr_addr[3];

    upload_port #(.DEPTH(depth_of(gi)), .OFS_W(OFS_W)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_hit[gi]),
      .set_val(wr_data[OFS_W-1:0]),
      .data_en(data_hit[gi]),
      .wr_en  (port_we[gi]),
      .wr_idx (port_idx[gi]),
      .err    (err_o[gi])
    );
  end

  for (genvar gi = 0; gi < NUM_PORT; gi++) begin : g_mem
    localparam int unsigned D  = depth_of(gi);
    localparam int unsigned AW = $clog2(D);
    localparam logic [OFS_W-1:0] LIM = OFS_W'(D);

    logic              we;
    logic [OFS_W-1:0]  widx;
    logic [DATA_W-1:0] rdata;

    if (gi >= 2) begin : g_shared
      logic mirror;
      assign mirror = port_we[gi-2] && !excl_q && (port_idx[gi-2] < LIM);
      assign we     = port_we[gi] || mirror;
      assign widx   = port_we[gi] ? port_idx[gi] : port_idx[gi-2];
    end else begin : g_solo
      assign we   = port_we[gi];
      assign widx = port_idx[gi];
    end

    shader_mem #(.DEPTH(D), .DATA_W(DATA_W)) u_mem (
      .clk  (clk),
      .we   (we),
      .waddr(widx[AW-1:0]),
      .wdata(wr_data),
      .raddr(rd_addr[AW-1:0]),
      .rdata(rdata)
    );

    assign mem_rd[gi] = (rd_addr < LIM) ? rdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem_rd[rd_sel];
  end

  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_hit, data_hit}));

  assert_no_reverse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit[2] || data_hit[3]) |-> !port_we[0] && !port_we[1]);

  assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr[9:8] == 2'b00) |=> err_o == 4'b0000);
endmodule

// File: tb/shader_upload_ctrl_test.sv
module shader_upload_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shader_upload_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .rd_data(rd_data), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one command; returns on the falling edge after the capturing edge
  task automatic cmd(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = 10'h3FF; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_sel = s; rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 err", {28'd0, err_o}, 32'd0);
    check("R1 ready", {31'd0, wr_ready}, 32'd1);
    cmd(10'h308, 32'hA0A0_0000);
    check("R1 err after write", {28'd0, err_o}, 32'd0);
    rd(2'd0, 16'd0, v); check("R1 first word at index 0", v, 32'hA0A0_0000);
    rd(2'd2, 16'd0, v); check("R6 shared by default", v, 32'hA0A0_0000);
    rd(2'd0, 16'd600, v); check("R11 out-of-range read", v, 32'd0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    for (int k = 1; k < 8; k++) cmd(10'h308 + 10'(k), 32'hB000_0000 + 32'(k));
    for (int k = 1; k < 8; k++) begin
      rd(2'd0, 16'(k), v); check("R2 alias write", v, 32'hB000_0000 + 32'(k));
    end
    cmd(10'h30F, 32'hB000_0008);
    rd(2'd0, 16'd8, v); check("R3 increment", v, 32'hB000_0008);
  endtask

  task automatic t_separate();
    logic [31:0] v;
    cmd(10'h318, 32'hC000_0000);
    cmd(10'h308, 32'hC000_0009);
    rd(2'd1, 16'd0, v); check("R5 pattern port own pointer", v, 32'hC000_0000);
    rd(2'd0, 16'd9, v); check("R5 program pointer unmoved", v, 32'hC000_0009);
    rd(2'd3, 16'd0, v); check("R6 pattern mirrored", v, 32'hC000_0000);
  endtask

  task automatic t_setofs();
    logic [31:0] v;
    cmd(10'h300, 32'd100);
    cmd(10'h30C, 32'hD000_0100);
    cmd(10'h30D, 32'hD000_0101);
    rd(2'd0, 16'd100, v); check("R9 loaded pointer", v, 32'hD000_0100);
    rd(2'd0, 16'd101, v); check("R9 then increments", v, 32'hD000_0101);
    rd(2'd2, 16'd101, v); check("R6 mirror same index", v, 32'hD000_0101);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    cmd(10'h300, 32'd511);
    cmd(10'h308, 32'hE000_0511);
    check("R4 last slot no error", {28'd0, err_o}, 32'd0);
    cmd(10'h308, 32'hEEEE_EEEE);
    check("R4 error primary program", {28'd0, err_o}, 32'h1);
    @(negedge clk);
    check("R4 error one cycle", {28'd0, err_o}, 32'd0);
    rd(2'd0, 16'd511, v); check("R4 last slot kept", v, 32'hE000_0511);
    rd(2'd2, 16'd511, v); check("R6 mirror at 511", v, 32'hE000_0511);
    cmd(10'h200, 32'd512);
    cmd(10'h208, 32'hEEEE_0512);
    check("R4 secondary program not full", {28'd0, err_o}, 32'd0);
    cmd(10'h308, 32'hEEEE_EEEE);
    check("R4 pointer stays at depth", {28'd0, err_o}, 32'h1);
    rd(2'd2, 16'd512, v); check("R11 secondary deeper", v, 32'hEEEE_0512);
    cmd(10'h210, 32'd128);
    cmd(10'h21B, 32'h1234_5678);
    check("R4 error secondary pattern", {28'd0, err_o}, 32'h8);
    cmd(10'h310, 32'd130);
    cmd(10'h318, 32'h1234_5678);
    check("R4 error primary pattern", {28'd0, err_o}, 32'h2);
    cmd(10'h200, 32'd4095);
    cmd(10'h208, 32'hF409_5000);
    cmd(10'h208, 32'hF409_6000);
    check("R4 error secondary program", {28'd0, err_o}, 32'h4);
    rd(2'd2, 16'd4095, v); check("R11 secondary last word", v, 32'hF409_5000);
  endtask

  task automatic t_exclusive();
    logic [31:0] v;
    cmd(10'h100, 32'h1);
    cmd(10'h200, 32'd20);
    cmd(10'h208, 32'h5EC0_0020);
    cmd(10'h300, 32'd20);
    cmd(10'h308, 32'h9410_0020);
    rd(2'd0, 16'd20, v); check("R7 primary written", v, 32'h9410_0020);
    rd(2'd2, 16'd20, v); check("R7 secondary untouched", v, 32'h5EC0_0020);
    cmd(10'h300, 32'd30);
    cmd(10'h308, 32'h9410_0030);
    cmd(10'h200, 32'd30);
    cmd(10'h20A, 32'h5EC0_0030);
    rd(2'd0, 16'd30, v); check("R8 primary not reached", v, 32'h9410_0030);
    rd(2'd2, 16'd30, v); check("R8 secondary written", v, 32'h5EC0_0030);
    cmd(10'h310, 32'd5);
    cmd(10'h319, 32'h9417_0005);
    cmd(10'h100, 32'h0);
    cmd(10'h310, 32'd5);
    cmd(10'h319, 32'h9418_0005);
    rd(2'd3, 16'd5, v); check("R6 sharing restored", v, 32'h9418_0005);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    cmd(10'h300, 32'd40);
    cmd(10'h308, 32'h4000_0040);
    cmd(10'h301, 32'd0);
    cmd(10'h0FF, 32'h1);
    cmd(10'h101, 32'h1);
    cmd(10'h320, 32'd0);
    check("R10 no error", {28'd0, err_o}, 32'd0);
    cmd(10'h308, 32'h4000_0041);
    rd(2'd0, 16'd41, v); check("R10 pointer unchanged", v, 32'h4000_0041);
    rd(2'd2, 16'd41, v); check("R10 sharing unchanged", v, 32'h4000_0041);
    rd(2'd0, 16'd40, v); check("R10 memory unchanged", v, 32'h4000_0040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_separate();
    t_setofs();
    t_overflow();
    t_exclusive();
    t_unmapped();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule